// File: doc/BRIEF.md
# Palette Colour Unit

This block turns pixel words arriving from a frame-buffer fetch stage into 16-bit RGB565 display colour. For indexed modes it looks each pixel up in a 256-entry colour table. The supported depths are 1, 2, 4 and 8 bits per pixel. In the 16-bit mode the pixel word already is an RGB565 colour, so it goes to the output without a lookup. Output colour and its qualifier appear one clock after the pixel is presented.

A simple register bus reads and writes the colour table and an override register. Table entry `i` sits at byte offset `0x400 + 4*i`. Setting the enable bit of the override register replaces every displayed pixel with one fixed colour, for example to blank the screen. The table RAM has a single port, and the display path owns it. A bus write to the table in a cycle where the display is looking up a pixel is discarded. Software reads the entry back to find out whether the write landed, and retries if it did not.

Top module: `palette_colour_unit`

## Requirements
- R1: After reset `rgbOut` and `rgbValid` are 0, every table entry reads back as 0 and the override register reads back as 0.
- R2: A bus write to byte offset `0x400 + 4*i` (i = 0..255) stores `busWrData[15:0]` into entry i. A bus read of that offset returns `{16'h0, entry}` on `busRdData` in the cycle after `busRdEn`. `busRdData` is 0 in any cycle that does not follow a read.
- R3: In mode code 3 (8 bpp), the pixel index is `pixData[7:0]`. The output is the selected entry, and entries hold RGB565 with red in bits 15:11, green in bits 10:5 and blue in bits 4:0.
- R4: In mode code 0 (1 bpp), the index is `pixData[0]`. In mode code 1 (2 bpp) it is `pixData[1:0]`. In mode code 2 (4 bpp) it is `pixData[3:0]`. In each of these modes the higher pixel bits have no effect.
- R5: Mode codes 4 to 7 (16 bpp) send `pixData` to `rgbOut` unchanged, with no table lookup.
- R6: The override register is at byte offset `0x50`. Bit 24 enables it and bits 23:0 hold a colour as red 23:16, green 15:8 and blue 7:0. A read returns bits 24:0 and zeros above. While the register is enabled, every valid pixel outputs `{red[7:3], green[7:2], blue[7:3]}`.
- R7: While the override enable bit is clear, pixels are looked up or bypassed normally, whatever colour the register holds.
- R8: A table write is discarded in any cycle where `pixValid` is high and the mode code is 0 to 3. A read-back then shows the earlier value. A table write in a 16 bpp pixel cycle is not discarded.
- R9: `rgbValid` equals `pixValid` of the previous cycle. `rgbOut` is 0 in the cycle after one with `pixValid` low.
- R10: Bus offsets outside the table window and other than `0x50` read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by bus and pixel path |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte offset of the bus access |
| busWrEn | input | 1 | Bus write strobe |
| busWrData | input | 32 | Bus write data |
| busRdEn | input | 1 | Bus read strobe |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| pixValid | input | 1 | Pixel word present |
| pixData | input | 16 | Pixel word (index or RGB565) |
| bppMode | input | 3 | Depth code: 0=1, 1=2, 2=4, 3=8, 4..7=16 bpp |
| rgbOut | output | 16 | RGB565 output colour |
| rgbValid | output | 1 | Output qualifier, pixValid delayed one cycle |

## Verification
The properties assume that a bus read and a bus write never fall in the same cycle. They also assume that `busAddr` is word aligned whenever either strobe is high. The stimulus issues every bus access as a single-cycle strobe followed by an idle cycle, and uses aligned offsets only. The override property further assumes that no second override write lands between the enabling write and the pixel it checks. The directed override sequences are ordered so that this holds.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int IDX_W  = 8;
  localparam int RGB_W  = 16;
  localparam int OVR_W  = 25;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic             palWe;
    logic             ovrWe;
    logic             rdPal;
    logic             rdOvr;
    logic [IDX_W-1:0] entryIdx;
  } ctrl_strb_t;

  function automatic logic [RGB_W-1:0] reduceColour(input logic [23:0] c);
    return {c[23:19], c[15:10], c[7:3]};
  endfunction
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import pcu_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAL_BASE = 'h400,
  parameter int OVR_ADDR = 'h050
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              pixValid,
  input  logic [MODE_W-1:0] bppMode,
  output ctrl_strb_t        strb
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [ADDR_W:0] PAL_END = (ADDR_W+1)'(PAL_BASE + 4 * ENTRIES);
  localparam logic [ADDR_W-1:0] PAL_LO = ADDR_W'(PAL_BASE);
  localparam logic [ADDR_W-1:0] OVR_A  = ADDR_W'(OVR_ADDR);

  logic [ADDR_W-1:0] offset;
  logic palHit;
  logic ovrHit;
  logic dispRead;
  logic unusedOffsetBits;

  always_comb begin
    offset   = busAddr - PAL_LO;
    palHit   = (busAddr >= PAL_LO) && ({1'b0, busAddr} < PAL_END);
    ovrHit   = (busAddr[ADDR_W-1:2] == OVR_A[ADDR_W-1:2]);
    dispRead = pixValid && (bppMode < MODE_W'(4));

    strb.palWe    = busWrEn && palHit && !dispRead;
    strb.ovrWe    = busWrEn && ovrHit;
    strb.rdPal    = busRdEn && palHit;
    strb.rdOvr    = busRdEn && ovrHit;
    strb.entryIdx = offset[IDX_W+1:2];
  end

  assign unusedOffsetBits = ^{offset[1:0], offset[ADDR_W-1:IDX_W+2]};
endmodule

// File: rtl/palette_datapath.sv
module palette_datapath
  import pcu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strb_t        strb,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              pixValid,
  input  logic [RGB_W-1:0]  pixData,
  input  logic [MODE_W-1:0] bppMode,
  output logic [RGB_W-1:0]  rgbOut,
  output logic              rgbValid
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [RGB_W-1:0] palMem [ENTRIES];
  logic [OVR_W-1:0] ovrReg;
  logic [IDX_W-1:0] lookupIdx;
  logic [RGB_W-1:0] pixNext;
  logic [DATA_W-1:0] rdNext;
  logic unusedWrHigh;

  assign unusedWrHigh = ^busWrData[DATA_W-1:OVR_W];

  // index masking per depth code
  always_comb begin
    case (bppMode)
      3'd0:    lookupIdx = {{(IDX_W-1){1'b0}}, pixData[0]};
      3'd1:    lookupIdx = {{(IDX_W-2){1'b0}}, pixData[1:0]};
      3'd2:    lookupIdx = {{(IDX_W-4){1'b0}}, pixData[3:0]};
      default: lookupIdx = pixData[IDX_W-1:0];
    endcase
  end

  always_comb begin
    if (!pixValid)              pixNext = '0;
    else if (ovrReg[OVR_W-1])   pixNext = reduceColour(ovrReg[23:0]);
    else if (bppMode[2])        pixNext = pixData;
    else                        pixNext = palMem[lookupIdx];
  end

  always_comb begin
    rdNext = '0;
    if (strb.rdPal)      rdNext[RGB_W-1:0] = palMem[strb.entryIdx];
    else if (strb.rdOvr) rdNext[OVR_W-1:0] = ovrReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) palMem[i] <= '0;
    end else if (strb.palWe) begin
      palMem[strb.entryIdx] <= busWrData[RGB_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrReg    <= '0;
      rgbOut    <= '0;
      rgbValid  <= 1'b0;
      busRdData <= '0;
    end else begin
      if (strb.ovrWe) ovrReg <= busWrData[OVR_W-1:0];
      rgbOut    <= pixNext;
      rgbValid  <= pixValid;
      busRdData <= rdNext;
    end
  end
endmodule

// File: rtl/palette_colour_unit.sv
module palette_colour_unit
  import pcu_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int PAL_BASE = 'h400,
  parameter int OVR_ADDR = 'h050
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  input  logic              pixValid,
  input  logic [15:0]       pixData,
  input  logic [2:0]        bppMode,
  output logic [15:0]       rgbOut,
  output logic              rgbValid
);
  ctrl_strb_t ctrlStrb;

  palette_ctrl #(
    .ADDR_W(ADDR_W), .PAL_BASE(PAL_BASE), .OVR_ADDR(OVR_ADDR)
  ) ctrl_i (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .pixValid(pixValid), .bppMode(bppMode), .strb(ctrlStrb)
  );

  palette_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(ctrlStrb),
    .busWrData(busWrData), .busRdData(busRdData),
    .pixValid(pixValid), .pixData(pixData), .bppMode(bppMode),
    .rgbOut(rgbOut), .rgbValid(rgbValid)
  );
endmodule

// File: rtl/palette_colour_unit_chk.sv
module palette_colour_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic [11:0] busAddr,
  input logic        busWrEn,
  input logic [31:0] busWrData,
  input logic        busRdEn,
  input logic [31:0] busRdData,
  input logic        pixValid,
  input logic [15:0] pixData,
  input logic [2:0]  bppMode,
  input logic [15:0] rgbOut,
  input logic        rgbValid,
  input logic        palWe,
  input logic        ovrWe,
  input logic        rdPal,
  input logic        rdOvr
);
  // R9: qualifier follows pixValid by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> rgbValid);
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> (!rgbValid && rgbOut == 16'h0));

  // R5: bypass in 16 bpp when no override was enabled just before
  a_r5_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 12'h050 && !busWrData[24]) ##1
    (pixValid && bppMode[2] && !busWrEn) |=> rgbOut == $past(pixData));

  // R6: override colour reaches the output
  a_r6_override: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 12'h050 && busWrData[24]) ##1
    (pixValid && !(busWrEn && busAddr == 12'h050)) |=>
    rgbOut == {$past(busWrData[23:19], 2), $past(busWrData[15:10], 2),
               $past(busWrData[7:3], 2)});

  // R8: display lookup blocks table writes
  a_r8_collision_drop: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !bppMode[2]) |-> !palWe);

  // R10: at most one write target per cycle
  a_r10_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({palWe, ovrWe}));

  // R2: read strobes only with a bus read, idle read data is zero
  a_r2_read_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (rdPal || rdOvr) |-> busRdEn);
  a_r2_read_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> busRdData == 32'h0);
endmodule

bind palette_colour_unit palette_colour_unit_chk chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
  .pixValid(pixValid), .pixData(pixData), .bppMode(bppMode),
  .rgbOut(rgbOut), .rgbValid(rgbValid),
  .palWe(ctrlStrb.palWe), .ovrWe(ctrlStrb.ovrWe),
  .rdPal(ctrlStrb.rdPal), .rdOvr(ctrlStrb.rdOvr)
);

// File: tb/palette_colour_unit_tb_top.sv
module palette_colour_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        pixValid = 1'b0;
  logic [15:0] pixData = '0;
  logic [2:0]  bppMode = '0;
  logic [15:0] rgbOut;
  logic        rgbValid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  palette_colour_unit dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .pixValid(pixValid), .pixData(pixData), .bppMode(bppMode),
    .rgbOut(rgbOut), .rgbValid(rgbValid)
  );

  // pixel vectors: {mode, pixel word}
  localparam int NVEC = 10;
  localparam logic [18:0] VEC [NVEC] = '{
    {3'd0, 16'hFFFF}, {3'd0, 16'h00FE}, {3'd1, 16'h00F6}, {3'd2, 16'hABCD},
    {3'd2, 16'h0010}, {3'd3, 16'h12FE}, {3'd3, 16'h0000}, {3'd4, 16'hBEEF},
    {3'd7, 16'h1234}, {3'd3, 16'h00FF}
  };

  function automatic logic [15:0] palVal(input int i);
    return 16'(i * 257) ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] refPix(input logic [2:0] m, input logic [15:0] p);
    case (m)
      3'd0:    return palVal(int'(p[0]));
      3'd1:    return palVal(int'(p[1:0]));
      3'd2:    return palVal(int'(p[3:0]));
      3'd3:    return palVal(int'(p[7:0]));
      default: return p;
    endcase
  endfunction

  function automatic logic [15:0] refOvr(input logic [23:0] c);
    return {c[23:19], c[15:10], c[7:3]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    d = busRdData; busRdEn = 1'b0;
  endtask

  task automatic pixStep(input logic [2:0] m, input logic [15:0] p, input string tag,
                         input logic [15:0] exp);
    @(negedge clk);
    pixValid = 1'b1; bppMode = m; pixData = p;
    @(negedge clk);
    check(tag, {16'h0, rgbOut}, {16'h0, exp});
    pixValid = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rgbOut", {16'h0, rgbOut}, 32'h0);
    check("R1 rgbValid", {31'h0, rgbValid}, 32'h0);
    busRead(12'h41C, rd); check("R1 entry7", rd, 32'h0);
    busRead(12'h050, rd); check("R1 override", rd, 32'h0);

    // load table, upper data bits set to show they are dropped
    for (int i = 0; i < 256; i++) busWrite(12'(12'h400 + 4 * i), {16'hDEAD, palVal(i)});
    busRead(12'h400, rd); check("R2 entry0", rd, {16'h0, palVal(0)});
    busRead(12'h7FC, rd); check("R2 entry255", rd, {16'h0, palVal(255)});
    busRead(12'h5A8, rd); check("R2 entry106", rd, {16'h0, palVal(106)});
    @(negedge clk); check("R2 idle read data", busRdData, 32'h0);

    // table-driven pixel sweep
    for (int v = 0; v < NVEC; v++) begin
      automatic logic [2:0] m = VEC[v][18:16];
      automatic logic [15:0] p = VEC[v][15:0];
      pixStep(m, p, (m < 3) ? "R4 masked lookup" : (m == 3) ? "R3 lookup" : "R5 bypass",
              refPix(m, p));
    end

    // R9 streaming latency and valid
    @(negedge clk);
    pixValid = 1'b1; bppMode = 3'd4; pixData = 16'h0F0F;
    @(negedge clk);
    check("R9 valid high", {31'h0, rgbValid}, 32'h1);
    check("R9 first", {16'h0, rgbOut}, 32'h0F0F);
    pixData = 16'hF0F0;
    @(negedge clk);
    check("R9 second", {16'h0, rgbOut}, 32'hF0F0);
    pixValid = 1'b0;
    @(negedge clk);
    check("R9 valid low", {31'h0, rgbValid}, 32'h0);
    check("R9 out zero", {16'h0, rgbOut}, 32'h0);

    // R8 collision: write during 8 bpp lookup is lost
    @(negedge clk);
    pixValid = 1'b1; bppMode = 3'd3; pixData = 16'h0005;
    busAddr = 12'h414; busWrData = 32'h7777; busWrEn = 1'b1;
    @(negedge clk);
    check("R8 display wins", {16'h0, rgbOut}, {16'h0, palVal(5)});
    busWrEn = 1'b0; pixValid = 1'b0;
    busRead(12'h414, rd); check("R8 dropped write readback", rd, {16'h0, palVal(5)});
    busWrite(12'h414, 32'h7777);
    busRead(12'h414, rd); check("R8 retry lands", rd, 32'h7777);
    // write during 16 bpp pixel is kept
    @(negedge clk);
    pixValid = 1'b1; bppMode = 3'd4; pixData = 16'h0006;
    busAddr = 12'h418; busWrData = 32'h1111; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; pixValid = 1'b0;
    busRead(12'h418, rd); check("R8 bypass write kept", rd, 32'h1111);

    // R6 override
    busWrite(12'h050, 32'h01123456);
    pixStep(3'd3, 16'h0010, "R6 override 8bpp", refOvr(24'h123456));
    pixStep(3'd4, 16'hBEEF, "R6 override 16bpp", refOvr(24'h123456));
    busRead(12'h050, rd); check("R6 readback", rd, 32'h01123456);
    busWrite(12'h050, 32'hFE00FF00);
    busRead(12'h050, rd); check("R6 high bits dropped", rd, 32'h0000FF00);
    // R7 disabled override keeps colour but not used
    busWrite(12'h050, 32'h00123456);
    pixStep(3'd3, 16'h0010, "R7 normal lookup", palVal(16));
    pixStep(3'd5, 16'h4321, "R7 normal bypass", 16'h4321);

    // R10 unmapped
    busWrite(12'h060, 32'hFFFFFFFF);
    busRead(12'h060, rd); check("R10 unmapped read", rd, 32'h0);
    busRead(12'h800, rd); check("R10 above window", rd, 32'h0);
    busRead(12'h3FC, rd); check("R10 below window", rd, 32'h0);
    busRead(12'h050, rd); check("R10 override untouched", rd, 32'h00123456);
    busWrite(12'h3FC, 32'h2222);
    busRead(12'h400, rd); check("R10 entry0 untouched", rd, {16'h0, palVal(0)});

    done = 1'b1;
    summary();
    $finish;
  end
endmodule